// File: doc/BRIEF.md
# Convert-Triggered Serial ADC Interface Emulator

This block stands in for a 12-bit serial analog-to-digital converter on the device side of a three-wire link. A host raises a convert line to start a conversion, lowers it to read the result, and supplies a serial clock. The emulator takes its result word from a parallel input bus. It captures that bus when the convert line rises. It then passes through a timed conversion state and a sleep state. When the convert line falls, it returns the captured code most significant bit first on a serial data output that can be tri-stated.

All pins are sampled by a fast system clock through two-flop synchronizers. Edges are found by comparing the synchronized level with its previous value. The output is modelled as a data bit plus a drive enable. While the enable is low, the pin is taken to be high-impedance.

The emulator also checks the host's timing. If the convert line rises again before the previous conversion time has elapsed, an error flag is raised and the newly captured word is replaced by zeros.

Top module: `sadc_emu`

## Requirements
- R1: A rising edge on `convPin` captures `sampleIn`, and `sdoEn` is 0 from 3 system clocks after the edge for as long as conversion lasts.
- R2: When `CONV_CYCLES` system clocks pass with `convPin` still high, the emulator moves to sleep and `sdoEn` stays 0.
- R3: A falling edge on `convPin` after a conversion sets `sdoEn` to 1 and puts bit 11 of the captured word on `sdoData` within 3 system clocks, before any serial clock edge.
- R4: Each falling edge of `sclkPin` while `sdoEn` is 1 moves `sdoData` to the next lower bit, so bits 11 down to 0 appear in order.
- R5: Once bit 0 has been presented, every further falling edge of `sclkPin` with `convPin` low leaves `sdoData` at 0.
- R6: The serial word is plain unsigned binary equal to the captured `sampleIn`. 12'h000 is sent as twelve zeros and 12'hFFF as twelve ones. Changes on `sampleIn` after the capture do not alter it.
- R7: A rising edge on `convPin` less than `CONV_CYCLES` system clocks after the previous rising edge sets `convErr` to 1 and makes the next word all zeros. The next rising edge that respects the conversion time clears `convErr` to 0.
- R8: Falling edges of `sclkPin` while `sdoEn` is 0 have no effect: the next transmit still starts at bit 11.
- R9: After reset, `sdoEn` and `convErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast relative to the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 12 | Parallel result code to be reported |
| convPin | input | 1 | Convert line from the host |
| sclkPin | input | 1 | Serial clock from the host |
| sdoData | output | 1 | Serial data bit, meaningful when sdoEn is 1 |
| sdoEn | output | 1 | Serial output drive enable (0 = high-impedance) |
| convErr | output | 1 | Convert line rose before the conversion time had passed |

## Verification
The assertions assume the host holds each serial clock phase and each convert line level for at least four system clocks. They also assume `sampleIn` is stable for three system clocks after the convert line rises, so that every pin change reaches the edge detectors as a single clean edge. The bench drives every pin on the falling system clock edge, holds each phase for exactly four cycles, and changes `sampleIn` only after the capture window. Premature convert edges are created on purpose, but still at four-cycle spacing, so that the error path is exercised without breaking the synchronizer assumption.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_XMIT  = 2'd3
  } adcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureSample;  // store parallel input as the result word
    logic invalidWord;    // store an all-zero word instead
    logic loadWord;       // copy result word into the shifter
    logic shiftBit;       // advance the shifter one bit
  } dpStrobe_t;

endpackage

// File: rtl/sadc_pin_sync.sv
module sadc_pin_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] pinsIn,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic metaQ, syncQ, prevQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaQ <= 1'b0;
        syncQ <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        metaQ <= pinsIn[i];
        syncQ <= metaQ;
        prevQ <= syncQ;
      end
    end

    assign lvl[i]  = syncQ;
    assign rise[i] = syncQ & ~prevQ;
    assign fall[i] = ~syncQ & prevQ;
  end

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int CONV_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convRise,
  input  logic       convFall,
  input  logic       sclkFall,
  output dpStrobe_t  strobe,
  output logic       sdoEn,
  output logic       convErr
);

  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam logic [TW-1:0] TIMER_LOAD = TW'(CONV_CYCLES);

  adcState_t       state;
  logic [TW-1:0]   timer;
  logic            timerBusy;
  logic            readable;

  assign timerBusy = (timer != '0);
  assign readable  = (state == ST_CONV) || (state == ST_SLEEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      convErr <= 1'b0;
    end else if (convRise) begin
      state   <= ST_CONV;
      timer   <= TIMER_LOAD;
      convErr <= timerBusy;
    end else begin
      if (timerBusy) timer <= timer - 1'b1;
      unique case (state)
        ST_CONV: begin
          if (convFall)        state <= ST_XMIT;
          else if (!timerBusy) state <= ST_SLEEP;
        end
        ST_SLEEP: if (convFall) state <= ST_XMIT;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.captureSample = convRise && !timerBusy;
    strobe.invalidWord   = convRise && timerBusy;
    strobe.loadWord      = convFall && readable && !convRise;
    strobe.shiftBit      = sclkFall && (state == ST_XMIT) && !convRise;
  end

  assign sdoEn = (state == ST_XMIT);

  // R1
  no_drive_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    convRise |=> !sdoEn);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !timerBusy && !convFall && !convRise) |=> (state == ST_SLEEP && !sdoEn));

  // R3
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convFall && readable && !convRise) |=> sdoEn);

  // R7
  early_rise_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convRise && timerBusy) |=> convErr);

  // R7
  clean_rise_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convRise && !timerBusy) |=> !convErr);

endmodule

// File: rtl/sadc_dpath.sv
module sadc_dpath
  import sadc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] sampleIn,
  input  dpStrobe_t    strobe,
  output logic         sdoData
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic [W-1:0]  wordReg;
  logic [W-1:0]  shiftReg;
  logic [CW-1:0] bitsSent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobe.captureSample) begin
      wordReg <= sampleIn;
    end else if (strobe.invalidWord) begin
      wordReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsSent <= '0;
    end else if (strobe.loadWord) begin
      shiftReg <= wordReg;
      bitsSent <= '0;
    end else if (strobe.shiftBit) begin
      shiftReg <= {shiftReg[W-2:0], 1'b0};
      if (bitsSent != CNT_MAX) bitsSent <= bitsSent + 1'b1;
    end
  end

  assign sdoData = shiftReg[W-1];

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> sdoData == $past(wordReg[W-1]));

  // R5
  zeros_after_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitsSent == CNT_MAX) |-> !sdoData);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.captureSample && !strobe.invalidWord) |=> $stable(wordReg));

endmodule

// File: rtl/sadc_emu.sv
module sadc_emu
  import sadc_pkg::*;
#(
  parameter int W           = 12,
  parameter int CONV_CYCLES = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] sampleIn,
  input  logic         convPin,
  input  logic         sclkPin,
  output logic         sdoData,
  output logic         sdoEn,
  output logic         convErr
);

  localparam int PIN_CONV = 0;
  localparam int PIN_SCLK = 1;

  logic [1:0] pinLvl, pinRise, pinFall;
  dpStrobe_t  strobe;

  sadc_pin_sync #(.N(2)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinsIn ({sclkPin, convPin}),
    .lvl    (pinLvl),
    .rise   (pinRise),
    .fall   (pinFall)
  );

  sadc_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .convRise (pinRise[PIN_CONV]),
    .convFall (pinFall[PIN_CONV]),
    .sclkFall (pinFall[PIN_SCLK]),
    .strobe   (strobe),
    .sdoEn    (sdoEn),
    .convErr  (convErr)
  );

  sadc_dpath #(.W(W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobe   (strobe),
    .sdoData  (sdoData)
  );

  // R8
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sdoEn && pinFall[PIN_SCLK] && !pinFall[PIN_CONV]) |=> $stable(sdoData));

  logic unusedLvl;
  assign unusedLvl = ^pinLvl;

endmodule

// File: tb/sim_sadc_emu.sv
`timescale 1ns/1ps
module sim_sadc_emu;

  localparam int W    = 12;
  localparam int CONV = 40;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         convPin = 1'b0;
  logic         sclkPin = 1'b0;
  logic         sdoData, sdoEn, convErr;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  sadc_emu #(.W(W), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .convPin(convPin),
    .sclkPin(sclkPin), .sdoData(sdoData), .sdoEn(sdoEn), .convErr(convErr)
  );

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one sclk pulse, then sample just before the next rising edge
  task automatic pulse();
    sclkPin = 1'b1; waitN(4);
    sclkPin = 1'b0; waitN(4);
  endtask

  task automatic readWord(input logic [W-1:0] expWord, input int extra);
    check("R3 first bit", int'(sdoData), int'(expWord[W-1]));
    for (int k = 1; k < W + extra; k++) begin
      pulse();
      if (k < W) check("R4 bit order", int'(sdoData), int'((expWord >> (W-1-k)) & 1));
      else       check("R5 trailing zero", int'(sdoData), 0);
    end
  endtask

  task automatic frame(input logic [W-1:0] s, input logic expErr);
    sampleIn = s; convPin = 1'b1;
    waitN(3);
    check("R1 hi-z in conversion", int'(sdoEn), 0);
    sampleIn = ~s;  // R6: late change must be ignored
    waitN(CONV + 8);
    check("R2 hi-z in sleep", int'(sdoEn), 0);
    check("R7 error flag", int'(convErr), int'(expErr));
    convPin = 1'b0; waitN(4);
    check("R3 output enabled", int'(sdoEn), 1);
    readWord(s, 3);
  endtask

  initial begin
    waitN(3);
    check("R9 reset enable", int'(sdoEn), 0);
    check("R9 reset error", int'(convErr), 0);
    rstN = 1'b1;
    waitN(3);

    // R6 extremes and neighbours
    frame(12'h000, 1'b0);
    frame(12'hFFF, 1'b0);
    frame(12'h001, 1'b0);
    frame(12'hFFE, 1'b0);
    for (int b = 0; b < W; b++) frame(W'(1 << b), 1'b0);
    for (int v = 0; v < 4096; v += 37) frame(W'(v), 1'b0);

    // R8: clocks in sleep must not advance the shifter
    sampleIn = 12'hA5C; convPin = 1'b1;
    waitN(CONV + 8);
    for (int p = 0; p < 3; p++) pulse();
    check("R8 still disabled", int'(sdoEn), 0);
    convPin = 1'b0; waitN(4);
    readWord(12'hA5C, 1);

    // R7: premature rise
    sampleIn = 12'h7F3; convPin = 1'b1; waitN(10);
    convPin = 1'b0; waitN(4);
    sampleIn = 12'h3C6; convPin = 1'b1; waitN(4);
    check("R7 error set", int'(convErr), 1);
    waitN(CONV + 8);
    convPin = 1'b0; waitN(4);
    check("R7 output enabled", int'(sdoEn), 1);
    for (int k = 0; k < W; k++) begin
      check("R7 invalid word zero", int'(sdoData), 0);
      pulse();
    end
    frame(12'h9B1, 1'b0);  // clean rise clears the flag (R7)

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule